// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This block answers one question for each operand of a vectorised operation: which elements may run, and what a switched-off element must leave behind. A request carries the operand's register number, which file it belongs to (integer or floating point) and the offset of the element being worked on. The unit looks at whether that register is redirected at all. It then consults a predicate configuration table. There is one such table for each register file, so the two files are predicated independently. When predication applies, the unit reads an integer register through a read port, inverts the value if the entry asks for it, and returns the resulting XLEN-bit mask. It also returns the entry's zeroing flag and the mask bit selected by the element offset. Scalar operations are predicated in the same way whenever their register is redirected.

Each predicate entry holds an enable, an invert bit, a zeroing bit and the index of the integer register that supplies the mask. Entries are loaded through a plain write port. The redirection enables of the register remap tables come in as two plain bit vectors. An element offset of XLEN or more is reported as an error, because the mask width is the ceiling on vector length.

Requests enter on a valid/ready stream and results leave on a valid/ready stream. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result of an accepted request appears on the next cycle with `out_valid` high. It stays there, unchanged, until a cycle in which `out_ready` is high. `in_ready` is high exactly when the output holds nothing or is being drained in the same cycle, so back-pressure on the output stalls the input with no bubble.

Top module: `pmask_lookup`

## Requirements
- R1: The integer table (`cfg_fp`=0, `in_fp`=0) and the floating-point table (`cfg_fp`=1, `in_fp`=1) are separate. A write to one never changes the result of a lookup in the other.
- R2: If the remap enable of the requested register (bit `in_reg` of `remap_act_int`, or of `remap_act_fp` when `in_fp`=1) is 0, the mask is all ones and the zeroing flag is 0.
- R3: If the remap enable is 1 but the predicate entry's enable is 0, the mask is all ones and the zeroing flag is 0.
- R4: If both enables are 1 and the invert bit is 0, `rf_raddr` equals the entry's index field and the mask equals the value on `rf_rdata`.
- R5: If both enables are 1 and the invert bit is 1, the mask is the bitwise complement of the value read.
- R6: When predication applies (R4 or R5), the zeroing flag equals the entry's zero bit.
- R7: For an offset below XLEN, `out_elem_en` equals bit number `in_offset` of the mask (bit 0 is the least significant) and `out_err` is 0.
- R8: For an offset of XLEN or more, `out_elem_en` is 0 and `out_err` is 1.
- R9: An accepted request produces its result on the next cycle. The result holds stable while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R10: After reset `out_valid` is 0 and every predicate entry in both tables is disabled.
- R11: A table write is visible to requests accepted on later cycles. A request accepted in the same cycle as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_fp | input | 1 | Operand file: 0 integer, 1 floating point |
| in_reg | input | RAW (5) | Operand register number |
| in_offset | input | OFFW (7) | Element offset within the vector |
| remap_act_int | input | NREG (32) | Remap enables of the integer registers |
| remap_act_fp | input | NREG (32) | Remap enables of the floating-point registers |
| cfg_we | input | 1 | Write one predicate entry |
| cfg_fp | input | 1 | Table written: 0 integer, 1 floating point |
| cfg_reg | input | RAW (5) | Entry written |
| cfg_act | input | 1 | New entry enable |
| cfg_inv | input | 1 | New entry invert bit |
| cfg_zero | input | 1 | New entry zeroing bit |
| cfg_idx | input | RAW (5) | New entry mask register index |
| rf_raddr | output | RAW (5) | Integer register file read address |
| rf_rdata | input | XLEN (64) | Read data, same-cycle return |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_mask | output | XLEN (64) | Predicate mask |
| out_zero | output | 1 | Zeroing mode |
| out_elem_en | output | 1 | Element enabled |
| out_err | output | 1 | Element offset out of range |

## Verification
All four results of a request are due together, one cycle after the edge that accepted it. The register read must be answered inside the accepting cycle. The bench drives its inputs on the falling edge. It waits a moment and then decides, from the levels that the next rising edge will see, whether a request is accepted and whether a result is taken. It queues the expected result at acceptance and pops it when the output handshake completes. It also requires that a result is on the port exactly when the queue holds one, and that a stalled result is still bit-identical one cycle later.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

  typedef enum logic {
    PM_FILE_INT = 1'b0,
    PM_FILE_FP  = 1'b1
  } pm_file_e;

  typedef enum logic [1:0] {
    PM_SRC_UNMAPPED = 2'd0,
    PM_SRC_UNPRED   = 2'd1,
    PM_SRC_DIRECT   = 2'd2,
    PM_SRC_INVERTED = 2'd3
  } pm_src_e;

endpackage

// File: rtl/pmask_table.sv
module pmask_table #(
  parameter int NREG = 32,
  parameter int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_reg,
  input  logic           wr_act,
  input  logic           wr_inv,
  input  logic           wr_zero,
  input  logic [RAW-1:0] wr_idx,
  input  logic [RAW-1:0] rd_reg,
  output logic           rd_act,
  output logic           rd_inv,
  output logic           rd_zero,
  output logic [RAW-1:0] rd_idx
);

  logic [NREG-1:0] act_q;
  logic [NREG-1:0] inv_q;
  logic [NREG-1:0] zero_q;
  logic [RAW-1:0]  idx_q [NREG];

  for (genvar e = 0; e < NREG; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_reg == RAW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[e]  <= 1'b0;
        inv_q[e]  <= 1'b0;
        zero_q[e] <= 1'b0;
        idx_q[e]  <= '0;
      end else if (hit) begin
        act_q[e]  <= wr_act;
        inv_q[e]  <= wr_inv;
        zero_q[e] <= wr_zero;
        idx_q[e]  <= wr_idx;
      end
    end
  end

  assign rd_act  = act_q[rd_reg];
  assign rd_inv  = inv_q[rd_reg];
  assign rd_zero = zero_q[rd_reg];
  assign rd_idx  = idx_q[rd_reg];

endmodule

// File: rtl/pmask_source.sv
module pmask_source
  import pmask_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            remap_on,
  input  logic            pred_act,
  input  logic            pred_inv,
  input  logic            pred_zero,
  input  logic [XLEN-1:0] rf_value,
  output logic [XLEN-1:0] mask,
  output logic            zero
);

  pm_src_e src;

  always_comb begin
    if (!remap_on)      src = PM_SRC_UNMAPPED;
    else if (!pred_act) src = PM_SRC_UNPRED;
    else if (pred_inv)  src = PM_SRC_INVERTED;
    else                src = PM_SRC_DIRECT;
  end

  always_comb begin
    unique case (src)
      PM_SRC_DIRECT: begin
        mask = rf_value;
        zero = pred_zero;
      end
      PM_SRC_INVERTED: begin
        mask = ~rf_value;
        zero = pred_zero;
      end
      default: begin
        mask = '1;
        zero = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pmask_elem.sv
module pmask_elem #(
  parameter int XLEN = 64,
  parameter int OFFW = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] mask,
  input  logic [OFFW-1:0] offset,
  output logic            elem_en,
  output logic            err
);

  localparam int LW = $clog2(XLEN);

  logic [LW-1:0] bit_sel;

  assign bit_sel = offset[LW-1:0];
  assign err     = (offset >= OFFW'(XLEN));
  assign elem_en = !err && mask[bit_sel];

endmodule

// File: rtl/pmask_lookup.sv
module pmask_lookup
  import pmask_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int RAW  = $clog2(NREG),
  parameter int OFFW = $clog2(XLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_fp,
  input  logic [RAW-1:0]  in_reg,
  input  logic [OFFW-1:0] in_offset,
  input  logic [NREG-1:0] remap_act_int,
  input  logic [NREG-1:0] remap_act_fp,
  input  logic            cfg_we,
  input  logic            cfg_fp,
  input  logic [RAW-1:0]  cfg_reg,
  input  logic            cfg_act,
  input  logic            cfg_inv,
  input  logic            cfg_zero,
  input  logic [RAW-1:0]  cfg_idx,
  output logic [RAW-1:0]  rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_mask,
  output logic            out_zero,
  output logic            out_elem_en,
  output logic            out_err
);

  localparam int NFILE = 2;

  logic           t_act  [NFILE];
  logic           t_inv  [NFILE];
  logic           t_zero [NFILE];
  logic [RAW-1:0] t_idx  [NFILE];

  for (genvar f = 0; f < NFILE; f++) begin : g_file
    pmask_table #(.NREG(NREG), .RAW(RAW)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_fp == 1'(f))),
      .wr_reg  (cfg_reg),
      .wr_act  (cfg_act),
      .wr_inv  (cfg_inv),
      .wr_zero (cfg_zero),
      .wr_idx  (cfg_idx),
      .rd_reg  (in_reg),
      .rd_act  (t_act[f]),
      .rd_inv  (t_inv[f]),
      .rd_zero (t_zero[f]),
      .rd_idx  (t_idx[f])
    );
  end

  pm_file_e       file_sel;
  logic           remap_on;
  logic           sel_act;
  logic           sel_inv;
  logic           sel_zero;
  logic [RAW-1:0] sel_idx;

  assign file_sel = pm_file_e'(in_fp);

  always_comb begin
    if (file_sel == PM_FILE_FP) begin
      remap_on = remap_act_fp[in_reg];
      sel_act  = t_act[1];
      sel_inv  = t_inv[1];
      sel_zero = t_zero[1];
      sel_idx  = t_idx[1];
    end else begin
      remap_on = remap_act_int[in_reg];
      sel_act  = t_act[0];
      sel_inv  = t_inv[0];
      sel_zero = t_zero[0];
      sel_idx  = t_idx[0];
    end
  end

  assign rf_raddr = sel_idx;

  logic [XLEN-1:0] mask_d;
  logic            zero_d;
  logic            en_d;
  logic            err_d;

  pmask_source #(.XLEN(XLEN)) u_src (
    .remap_on  (remap_on),
    .pred_act  (sel_act),
    .pred_inv  (sel_inv),
    .pred_zero (sel_zero),
    .rf_value  (rf_rdata),
    .mask      (mask_d),
    .zero      (zero_d)
  );

  pmask_elem #(.XLEN(XLEN), .OFFW(OFFW)) u_elem (
    .mask    (mask_d),
    .offset  (in_offset),
    .elem_en (en_d),
    .err     (err_d)
  );

  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_mask    <= '0;
      out_zero    <= 1'b0;
      out_elem_en <= 1'b0;
      out_err     <= 1'b0;
    end else if (accept) begin
      out_mask    <= mask_d;
      out_zero    <= zero_d;
      out_elem_en <= en_d;
      out_err     <= err_d;
    end
  end

endmodule

// File: rtl/pmask_lookup_chk.sv
module pmask_lookup_chk #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int RAW  = $clog2(NREG),
  parameter int OFFW = $clog2(XLEN) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_fp,
  input logic [RAW-1:0]  in_reg,
  input logic [OFFW-1:0] in_offset,
  input logic [NREG-1:0] remap_act_int,
  input logic [NREG-1:0] remap_act_fp,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_mask,
  input logic            out_zero,
  input logic            out_elem_en,
  input logic            out_err
);

  localparam int LW = $clog2(XLEN);

  logic            took;
  logic            mapped;
  logic [OFFW-1:0] off_q;

  assign took   = in_valid && in_ready;
  assign mapped = in_fp ? remap_act_fp[in_reg] : remap_act_int[in_reg];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (took) off_q <= in_offset;
  end

  a_r9_fill: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_zero)
                                && $stable(out_elem_en) && $stable(out_err));

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r2_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
    took && !mapped |=> (&out_mask) && !out_zero);

  a_r8_range_err: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_err == (off_q >= OFFW'(XLEN)));

  a_r8_err_disables: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> !out_elem_en);

  a_r7_bit_select: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_elem_en == out_mask[off_q[LW-1:0]]);

endmodule

bind pmask_lookup pmask_lookup_chk #(
  .XLEN(XLEN), .NREG(NREG), .RAW(RAW), .OFFW(OFFW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_fp         (in_fp),
  .in_reg        (in_reg),
  .in_offset     (in_offset),
  .remap_act_int (remap_act_int),
  .remap_act_fp  (remap_act_fp),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_mask      (out_mask),
  .out_zero      (out_zero),
  .out_elem_en   (out_elem_en),
  .out_err       (out_err)
);

// File: tb/tb_pmask_lookup.sv
module tb_pmask_lookup;

  localparam int XLEN = 64;
  localparam int NREG = 32;
  localparam int RAW  = 5;
  localparam int OFFW = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            in_fp = 1'b0;
  logic [RAW-1:0]  in_reg = '0;
  logic [OFFW-1:0] in_offset = '0;
  logic [NREG-1:0] remap_act_int = '0;
  logic [NREG-1:0] remap_act_fp = '0;
  logic            cfg_we = 1'b0;
  logic            cfg_fp = 1'b0;
  logic [RAW-1:0]  cfg_reg = '0;
  logic            cfg_act = 1'b0;
  logic            cfg_inv = 1'b0;
  logic            cfg_zero = 1'b0;
  logic [RAW-1:0]  cfg_idx = '0;
  logic [RAW-1:0]  rf_raddr;
  logic [XLEN-1:0] rf_rdata;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [XLEN-1:0] out_mask;
  logic            out_zero;
  logic            out_elem_en;
  logic            out_err;

  always #2.5 clk = ~clk;

  pmask_lookup dut (.*);

  // Bench-side register file and model of both predicate tables
  logic [XLEN-1:0] rf_model [NREG];
  logic            m_act  [2][NREG];
  logic            m_inv  [2][NREG];
  logic            m_zero [2][NREG];
  logic [RAW-1:0]  m_idx  [2][NREG];

  always_comb rf_rdata = rf_model[rf_raddr];

  typedef struct packed {
    logic [XLEN-1:0] mask;
    logic            zero;
    logic            en;
    logic            err;
  } exp_t;

  exp_t  q_exp [$];
  string q_tag [$];

  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;
  bit   hold_pend = 0;
  exp_t held;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic void predict(output exp_t e, output string tag);
    int  f;
    bit  mapped;
    logic [XLEN-1:0] v;
    f = in_fp ? 1 : 0;
    mapped = in_fp ? remap_act_fp[in_reg] : remap_act_int[in_reg];
    e.zero = 1'b0;
    if (!mapped) begin
      v = '1; tag = "R2";
    end else if (!m_act[f][in_reg]) begin
      v = '1; tag = "R3";
    end else begin
      v = rf_model[m_idx[f][in_reg]];
      e.zero = m_zero[f][in_reg];
      if (m_inv[f][in_reg]) begin v = ~v; tag = "R5"; end
      else tag = "R4";
    end
    e.mask = v;
    e.err  = (int'(in_offset) >= XLEN);
    e.en   = !e.err && v[in_offset[5:0]];
  endfunction

  task automatic evaluate();
    exp_t  e;
    string tag;
    // R9: ready rule
    chk(in_ready == (!out_valid || out_ready), "R9", "in_ready",
        XLEN'(in_ready), XLEN'(!out_valid || out_ready));
    if (hold_pend) begin
      chk(out_valid && out_mask == held.mask && out_zero == held.zero &&
          out_elem_en == held.en && out_err == held.err, "R9", "held result",
          out_mask, held.mask);
      hold_pend = 0;
    end
    // R9: a result is present exactly when one is owed (one-cycle latency)
    chk(out_valid == (q_exp.size() != 0), "R9", "out_valid vs pending",
        XLEN'(out_valid), XLEN'(q_exp.size()));
    if (out_valid && out_ready && q_exp.size() != 0) begin
      e = q_exp.pop_front();
      tag = q_tag.pop_front();
      chk(out_mask == e.mask, tag, "mask", out_mask, e.mask);
      chk(out_zero == e.zero, (tag == "R4" || tag == "R5") ? "R6" : tag, "zero",
          XLEN'(out_zero), XLEN'(e.zero));
      chk(out_elem_en == e.en, e.err ? "R8" : "R7", "elem_en",
          XLEN'(out_elem_en), XLEN'(e.en));
      chk(out_err == e.err, "R8", "err", XLEN'(out_err), XLEN'(e.err));
    end else if (out_valid) begin
      held = '{mask: out_mask, zero: out_zero, en: out_elem_en, err: out_err};
      hold_pend = 1;
    end
    // R11: prediction uses the tables before this cycle's write
    if (in_valid && in_ready) begin
      predict(e, tag);
      q_exp.push_back(e);
      q_tag.push_back(tag);
    end
    if (cfg_we) begin
      m_act[cfg_fp ? 1 : 0][cfg_reg]  = cfg_act;
      m_inv[cfg_fp ? 1 : 0][cfg_reg]  = cfg_inv;
      m_zero[cfg_fp ? 1 : 0][cfg_reg] = cfg_zero;
      m_idx[cfg_fp ? 1 : 0][cfg_reg]  = cfg_idx;
    end
  endtask

  task automatic tick();
    #1;
    evaluate();
    @(negedge clk);
  endtask

  task automatic req(input bit fp, input int r, input int off);
    in_valid = 1; in_fp = fp; in_reg = RAW'(r); in_offset = OFFW'(off);
  endtask

  task automatic wcfg(input bit fp, input int r, input bit a, input bit inv,
                      input bit z, input int idx);
    cfg_we = 1; cfg_fp = fp; cfg_reg = RAW'(r); cfg_act = a; cfg_inv = inv;
    cfg_zero = z; cfg_idx = RAW'(idx);
  endtask

  task automatic idle();
    in_valid = 0; cfg_we = 0;
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      rf_model[i] = {32'(i * 32'h9E3779B9), 32'(~i * 32'h85EBCA6B)};
      for (int f = 0; f < 2; f++) begin
        m_act[f][i] = 0; m_inv[f][i] = 0; m_zero[f][i] = 0; m_idx[f][i] = '0;
      end
    end
    rf_model[7] = 64'h0000_0000_0000_00A5;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10", "out_valid in reset", XLEN'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", XLEN'(out_valid), '0);
    out_ready = 1;
    // R2: nothing redirected
    req(0, 3, 5); tick();
    // R3 and R10: redirected, tables cleared by reset
    remap_act_int = '1; remap_act_fp = '1;
    req(0, 3, 5); tick();
    // R11: write and lookup in the same cycle sees the old entry
    wcfg(0, 3, 1, 0, 1, 7); req(0, 3, 1); tick();
    cfg_we = 0;
    // R4, R6: now predicated by x7
    req(0, 3, 0); tick();
    req(0, 3, 1); tick();
    // R1: floating-point entry 3 is still off
    req(1, 3, 0); tick();
    // R5: inverted entry
    wcfg(0, 4, 1, 1, 0, 7); idle(); in_valid = 0; cfg_we = 1; tick();
    cfg_we = 0;
    req(0, 4, 1); tick();
    req(0, 4, 63); tick();
    // R8: out-of-range offsets
    req(0, 3, 64); tick();
    req(0, 3, 127); tick();
    // R1: fp table write leaves the int entry alone
    wcfg(1, 3, 1, 1, 1, 9); in_valid = 0; tick();
    cfg_we = 0;
    req(0, 3, 2); tick();
    req(1, 3, 2); tick();
    // R9: back-pressure
    out_ready = 0;
    req(0, 4, 5); tick();
    req(0, 3, 6); tick();
    tick(); tick();
    out_ready = 1; tick();
    idle(); tick(); tick();
    // Mixed traffic
    for (int c = 0; c < 5000; c++) begin
      if (c % 64 == 0) begin
        remap_act_int = $urandom(); remap_act_fp = $urandom();
        for (int i = 0; i < NREG; i++) rf_model[i] = {$urandom(), $urandom()};
      end
      in_valid  = ($urandom() % 10) < 7;
      out_ready = ($urandom() % 10) < 7;
      in_fp     = $urandom();
      in_reg    = RAW'($urandom());
      in_offset = OFFW'($urandom());
      cfg_we    = ($urandom() % 10) < 2;
      cfg_fp    = $urandom(); cfg_reg = RAW'($urandom());
      cfg_act   = ($urandom() % 4) != 0; cfg_inv = $urandom();
      cfg_zero  = $urandom(); cfg_idx = RAW'($urandom());
      tick();
    end
    idle(); out_ready = 1;
    repeat (4) tick();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule